// File: doc/BRIEF.md
# Two-Rate Step Sequencer

This block sets the pace for the fast half of a real-time network solver that is split into a fast sub-network and a slow sub-network. It emits a one-cycle strobe at the start of every fast step. It groups a programmable number of fast steps into one slow interval. At the end of each interval it stops and raises a synchronization request toward the slow-side partner. It resumes only when the partner acknowledges.

Interface history crosses between the sides only at these barriers. The fast-side history value is captured on the last cycle of an interval. The partner's slow-side value is captured with the acknowledge. Between barriers the block produces a linearly interpolated estimate of the slow-side quantity for each sub-step. The estimate runs between the two most recently exchanged endpoints. Because of this, the value used in interval k was produced by the partner one interval earlier, and the two sides can compute in parallel.

The fast-step length in clock cycles and the steps-per-interval ratio are held in shadow registers. They are loaded from a write strobe and take effect only at the next interval start. Their reset defaults are 400 cycles (2 µs at 200 MHz) and 25 steps (one 50 µs slow step).

Top module: `msr_step_sequencer`

## Requirements
- R1: After reset, sync_req is 1, fast_step, overrun, substep_idx, interval_cnt, interp_val and hist_to_slow are all 0, and the active step length and ratio are 400 cycles and 25.
- R2: While an interval runs, fast_step is high for exactly one cycle at the start of each fast step, and consecutive strobes are exactly P cycles apart, where P is the active step length.
- R3: Within an interval, substep_idx holds 0, 1, ..., M-1 in turn, with each value held for P cycles starting at its strobe, where M is the active ratio.
- R4: sync_req rises on the cycle after the final cycle of sub-step M-1. interval_cnt increments at that same point. No strobe occurs while sync_req is high, and sync_req stays high until sync_ack is seen.
- R5: A cycle with sync_req and sync_ack both high starts the next interval. On the following cycle sync_req is 0, fast_step is 1 and substep_idx is 0.
- R6: On the acknowledge cycle, the start endpoint takes the previous end endpoint and the end endpoint takes slow_in. hist_to_slow takes fast_hist_in on the final cycle of an interval and is unchanged at every other time. slow_in and fast_hist_in have no effect at any other time.
- R7: interp_val equals the low 16 bits of a + floor((b - a) * i * r / 65536). Here a and b are the start and end endpoints as signed 16-bit values, i is substep_idx, and r = ceil(65536 / M).
- R8: If sync_req stays high without sync_ack for P consecutive cycles, overrun is 1 from the next cycle. It stays 1 until the cycle after the acknowledge, and the interval start is held until then.
- R9: A cfg_wr pulse loads cfg_period and cfg_ratio into shadow registers. These values become active only at the next interval start, so the running interval keeps its step length and ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load shadow step length and ratio |
| cfg_period | input | 16 | Fast-step length in clock cycles (at least 2) |
| cfg_ratio | input | 8 | Fast steps per slow interval (at least 1) |
| sync_ack | input | 1 | Partner has finished exchange and synchronization |
| slow_in | input | 16 | Slow-side interface value, signed, taken at acknowledge |
| fast_hist_in | input | 16 | Fast-side history value, taken on the last interval cycle |
| fast_step | output | 1 | One-cycle strobe at the start of each fast step |
| substep_idx | output | 8 | Current sub-step within the interval |
| interval_cnt | output | 16 | Number of completed slow intervals |
| sync_req | output | 1 | Waiting at the barrier for the partner |
| overrun | output | 1 | Partner acknowledge is late |
| interp_val | output | 16 | Interpolated slow-side estimate for this sub-step |
| hist_to_slow | output | 16 | Fast-side history value offered to the partner |

## Verification
The assertions take for granted that the active step length is at least 2 cycles and that the ratio is non-zero. The strobe-gap and index-range properties would not hold otherwise. They also assume cfg_wr never coincides with an acknowledge. The stimulus draws step lengths from 2 to 7 and ratios from 2 to 6, apart from one interval at the defaults. It places every configuration write either on a waiting cycle that precedes the acknowledge by at least one cycle, or on the second cycle of a running interval. Acknowledge delays are random or set directly on both sides of the overrun deadline. slow_in and fast_hist_in are driven with unrelated values outside their capture cycles.

// File: rtl/msr_pkg.sv
package msr_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;

  // Q(frac) reciprocal of the ratio, rounded up; zero ratio maps to zero.
  function automatic int unsigned recip_q(input int unsigned m, input int unsigned frac);
    if (m == 0) return 0;
    return ((32'd1 << frac) + m - 1) / m;
  endfunction

endpackage

// File: rtl/msr_cfg.sv
module msr_cfg
  import msr_pkg::*;
#(
  parameter int PW         = 16,
  parameter int MW         = 8,
  parameter int FRAC       = 16,
  parameter int DEF_PERIOD = 400,
  parameter int DEF_RATIO  = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [PW-1:0] cfg_period,
  input  logic [MW-1:0] cfg_ratio,
  input  logic          apply,
  output logic [PW-1:0] act_period,
  output logic [MW-1:0] act_ratio,
  output logic [FRAC:0] act_recip
);
  localparam int RW = FRAC + 1;
  localparam logic [PW-1:0] P0 = PW'(DEF_PERIOD);
  localparam logic [MW-1:0] M0 = MW'(DEF_RATIO);
  localparam logic [RW-1:0] R0 = RW'(recip_q(DEF_RATIO, FRAC));

  logic [PW-1:0] sh_period;
  logic [MW-1:0] sh_ratio;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_period  <= P0;
      sh_ratio   <= M0;
      act_period <= P0;
      act_ratio  <= M0;
      act_recip  <= R0;
    end else begin
      if (cfg_wr) begin
        sh_period <= cfg_period;
        sh_ratio  <= cfg_ratio;
      end
      if (apply) begin
        act_period <= sh_period;
        act_ratio  <= sh_ratio;
        act_recip  <= RW'(recip_q(32'(sh_ratio), FRAC));
      end
    end
  end
endmodule

// File: rtl/msr_seq_ctrl.sv
module msr_seq_ctrl
  import msr_pkg::*;
#(
  parameter int PW = 16,
  parameter int MW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] act_period,
  input  logic [MW-1:0] act_ratio,
  input  logic          sync_ack,
  output logic          fast_step,
  output logic [MW-1:0] substep_idx,
  output logic [CW-1:0] interval_cnt,
  output logic          sync_req,
  output logic          overrun,
  output logic          ev_start,
  output logic          ev_end
);
  seq_state_e    state;
  logic [PW-1:0] tcnt;
  logic          last_tick;
  logic          last_sub;

  assign last_tick = (tcnt == act_period - PW'(1));
  assign last_sub  = (substep_idx == act_ratio - MW'(1));
  assign ev_start  = (state == ST_WAIT) && sync_ack;
  assign ev_end    = (state == ST_RUN) && last_tick && last_sub;
  assign fast_step = (state == ST_RUN) && (tcnt == '0);
  assign sync_req  = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_WAIT;
      tcnt         <= '0;
      substep_idx  <= '0;
      interval_cnt <= '0;
      overrun      <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (last_tick) begin
            tcnt <= '0;
            if (last_sub) begin
              state        <= ST_WAIT;
              substep_idx  <= '0;
              interval_cnt <= interval_cnt + CW'(1);
            end else begin
              substep_idx <= substep_idx + MW'(1);
            end
          end else begin
            tcnt <= tcnt + PW'(1);
          end
        end
        default: begin
          if (sync_ack) begin
            state       <= ST_RUN;
            tcnt        <= '0;
            substep_idx <= '0;
            overrun     <= 1'b0;
          end else if (last_tick) begin
            overrun <= 1'b1;
          end else begin
            tcnt <= tcnt + PW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/msr_interp.sv
module msr_interp #(
  parameter int DW   = 16,
  parameter int MW   = 8,
  parameter int FRAC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_end,
  input  logic [DW-1:0] slow_in,
  input  logic [DW-1:0] fast_hist_in,
  input  logic [MW-1:0] substep_idx,
  input  logic [FRAC:0] act_recip,
  output logic [DW-1:0] interp_val,
  output logic [DW-1:0] hist_to_slow
);
  localparam int RW  = FRAC + 1;
  localparam int PRW = DW + MW + RW + 3;

  logic signed [DW-1:0] ep_a;
  logic signed [DW-1:0] ep_b;

  function automatic logic signed [DW-1:0] lerp(
    input logic signed [DW-1:0] a,
    input logic signed [DW-1:0] b,
    input logic        [MW-1:0] i,
    input logic        [RW-1:0] r
  );
    logic signed [PRW-1:0] d;
    logic signed [PRW-1:0] p;
    d = PRW'(b) - PRW'(a);
    p = d * $signed(PRW'(i)) * $signed(PRW'(r));
    return DW'(PRW'(a) + (p >>> FRAC));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_a         <= '0;
      ep_b         <= '0;
      hist_to_slow <= '0;
    end else begin
      if (ev_start) begin
        ep_a <= ep_b;
        ep_b <= $signed(slow_in);
      end
      if (ev_end) hist_to_slow <= fast_hist_in;
    end
  end

  assign interp_val = lerp(ep_a, ep_b, substep_idx, act_recip);
endmodule

// File: rtl/msr_step_sequencer.sv
module msr_step_sequencer #(
  parameter int PW         = 16,
  parameter int MW         = 8,
  parameter int CW         = 16,
  parameter int DW         = 16,
  parameter int FRAC       = 16,
  parameter int DEF_PERIOD = 400,
  parameter int DEF_RATIO  = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [PW-1:0] cfg_period,
  input  logic [MW-1:0] cfg_ratio,
  input  logic          sync_ack,
  input  logic [DW-1:0] slow_in,
  input  logic [DW-1:0] fast_hist_in,
  output logic          fast_step,
  output logic [MW-1:0] substep_idx,
  output logic [CW-1:0] interval_cnt,
  output logic          sync_req,
  output logic          overrun,
  output logic [DW-1:0] interp_val,
  output logic [DW-1:0] hist_to_slow
);
  logic [PW-1:0] act_period;
  logic [MW-1:0] act_ratio;
  logic [FRAC:0] act_recip;
  logic          ev_start;
  logic          ev_end;

  msr_cfg #(
    .PW(PW), .MW(MW), .FRAC(FRAC),
    .DEF_PERIOD(DEF_PERIOD), .DEF_RATIO(DEF_RATIO)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_period(cfg_period), .cfg_ratio(cfg_ratio),
    .apply(ev_start),
    .act_period(act_period), .act_ratio(act_ratio), .act_recip(act_recip)
  );

  msr_seq_ctrl #(.PW(PW), .MW(MW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .act_period(act_period), .act_ratio(act_ratio), .sync_ack(sync_ack),
    .fast_step(fast_step), .substep_idx(substep_idx), .interval_cnt(interval_cnt),
    .sync_req(sync_req), .overrun(overrun), .ev_start(ev_start), .ev_end(ev_end)
  );

  msr_interp #(.DW(DW), .MW(MW), .FRAC(FRAC)) u_interp (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_end(ev_end),
    .slow_in(slow_in), .fast_hist_in(fast_hist_in),
    .substep_idx(substep_idx), .act_recip(act_recip),
    .interp_val(interp_val), .hist_to_slow(hist_to_slow)
  );
endmodule

// File: rtl/msr_step_sequencer_chk.sv
module msr_step_sequencer_chk #(
  parameter int MW = 8,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fast_step,
  input logic [MW-1:0] substep_idx,
  input logic [CW-1:0] interval_cnt,
  input logic          sync_req,
  input logic          sync_ack,
  input logic          overrun,
  input logic [MW-1:0] act_ratio,
  input logic          ev_end,
  input logic [DW-1:0] hist_to_slow
);
  AST_NO_STROBE_AT_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> !fast_step); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req && !sync_ack |=> sync_req); // R4

  AST_ACK_STARTS_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req && sync_ack |=> fast_step && !sync_req && substep_idx == '0); // R5

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fast_step |=> !fast_step); // R2

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req |-> substep_idx < act_ratio); // R3

  AST_COUNT_AT_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_req) |-> interval_cnt == $past(interval_cnt) + CW'(1)); // R4

  AST_OVERRUN_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> sync_req); // R8

  AST_HIST_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_end |=> $stable(hist_to_slow)); // R6
endmodule

bind msr_step_sequencer msr_step_sequencer_chk #(.MW(MW), .CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fast_step(fast_step), .substep_idx(substep_idx),
  .interval_cnt(interval_cnt), .sync_req(sync_req), .sync_ack(sync_ack),
  .overrun(overrun), .act_ratio(act_ratio), .ev_end(ev_end),
  .hist_to_slow(hist_to_slow)
);

// File: tb/msr_step_sequencer_test.sv
`timescale 1ns/1ps
module msr_step_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_period = '0;
  logic [7:0]  cfg_ratio = '0;
  logic        sync_ack = 1'b0;
  logic [15:0] slow_in = '0;
  logic [15:0] fast_hist_in = '0;
  logic        fast_step;
  logic [7:0]  substep_idx;
  logic [15:0] interval_cnt;
  logic        sync_req;
  logic        overrun;
  logic [15:0] interp_val;
  logic [15:0] hist_to_slow;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cur_p = 400, cur_m = 25, sh_p = 400, sh_m = 25;
  int ep_a = 0, ep_b = 0, exp_cnt = 0;
  logic [15:0] exp_hist = '0;

  always #2.5 clk = ~clk;

  msr_step_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
    .cfg_ratio(cfg_ratio), .sync_ack(sync_ack), .slow_in(slow_in),
    .fast_hist_in(fast_hist_in), .fast_step(fast_step), .substep_idx(substep_idx),
    .interval_cnt(interval_cnt), .sync_req(sync_req), .overrun(overrun),
    .interp_val(interp_val), .hist_to_slow(hist_to_slow)
  );

  function automatic logic [15:0] est(input int a, input int b, input int i, input int m);
    longint r = (64'd65536 + longint'(m) - 1) / longint'(m);
    longint p = longint'(b - a) * longint'(i) * r;
    longint q = p >>> 16;
    return 16'(longint'(a) + q);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Starts in a waiting cycle at a negative edge, returns in the next waiting cycle.
  task automatic run_interval(input int delay, input bit do_wr, input bit wr_in_run,
                              input int wp, input int wm, input int slow, input int fastv);
    int dl = delay;
    if (do_wr && !wr_in_run && dl < 1) dl = 1;
    for (int j = 0; j <= dl; j++) begin
      chk(sync_req == 1'b1, "R4 req held", sync_req, 1);
      chk(fast_step == 1'b0, "R4 no strobe", fast_step, 0);
      chk(overrun == (j >= cur_p), "R8 overrun", overrun, (j >= cur_p));
      cfg_wr = 1'b0;
      if (j == 0 && do_wr && !wr_in_run) begin
        cfg_wr = 1'b1; cfg_period = 16'(wp); cfg_ratio = 8'(wm);
        sh_p = wp; sh_m = wm;
      end
      slow_in = 16'($urandom);
      if (j == dl) begin sync_ack = 1'b1; slow_in = 16'(slow); end
      @(negedge clk);
    end
    sync_ack = 1'b0; cfg_wr = 1'b0;
    ep_a = ep_b; ep_b = int'($signed(16'(slow)));
    cur_p = sh_p; cur_m = sh_m;
    for (int s = 0; s < cur_m; s++) begin
      for (int c = 0; c < cur_p; c++) begin
        chk(fast_step == (c == 0), "R2 strobe", fast_step, (c == 0));
        chk(substep_idx == 8'(s), "R3 index", substep_idx, s);
        chk(sync_req == 1'b0, "R5 running", sync_req, 0);
        chk(overrun == 1'b0, "R8 cleared", overrun, 0);
        if (c == 0) begin
          chk(interp_val == est(ep_a, ep_b, s, cur_m), "R7 interp", interp_val,
              est(ep_a, ep_b, s, cur_m));
          chk(hist_to_slow == exp_hist, "R6 hist held", hist_to_slow, exp_hist);
        end
        cfg_wr = 1'b0;
        if (do_wr && wr_in_run && s == 0 && c == 1) begin
          cfg_wr = 1'b1; cfg_period = 16'(wp); cfg_ratio = 8'(wm);
          sh_p = wp; sh_m = wm;
        end
        slow_in = 16'($urandom);
        fast_hist_in = 16'($urandom);
        if (s == cur_m - 1 && c == cur_p - 1) fast_hist_in = 16'(fastv);
        @(negedge clk);
      end
    end
    cfg_wr = 1'b0;
    exp_cnt++;
    exp_hist = 16'(fastv);
    chk(sync_req == 1'b1, "R4 barrier", sync_req, 1);
    chk(fast_step == 1'b0, "R4 barrier strobe", fast_step, 0);
    chk(interval_cnt == 16'(exp_cnt), "R4 count", interval_cnt, exp_cnt);
    chk(hist_to_slow == exp_hist, "R6 hist capture", hist_to_slow, exp_hist);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(sync_req == 1'b1, "R1 sync_req", sync_req, 1);
    chk(fast_step == 1'b0, "R1 fast_step", fast_step, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(substep_idx == 0, "R1 index", substep_idx, 0);
    chk(interval_cnt == 0, "R1 count", interval_cnt, 0);
    chk(interp_val == 0, "R1 interp", interp_val, 0);
    chk(hist_to_slow == 0, "R1 hist", hist_to_slow, 0);
    // R9 defaults 400/25, R1 active values
    run_interval(0, 1'b0, 1'b0, 0, 0, 1000, 16'h1234);
    // write while waiting, negative slope
    run_interval(2, 1'b1, 1'b0, 5, 3, -500, 77);
    // late ack (R8) plus mid-interval write that must not act yet (R9)
    run_interval(cur_p + 3, 1'b1, 1'b1, 4, 4, 300, 5);
    // R8 boundaries: just inside and exactly at the deadline
    run_interval(cur_p - 1, 1'b0, 1'b0, 0, 0, 32767, 9);
    run_interval(cur_p, 1'b0, 1'b0, 0, 0, -32768, 10);
    run_interval(0, 1'b1, 1'b0, 7, 6, 32767, 11);
    for (int n = 0; n < 30; n++) begin
      run_interval(int'($urandom_range(0, 9)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), int'($urandom_range(2, 7)),
                   int'($urandom_range(2, 6)), int'($signed(16'($urandom))),
                   int'($urandom_range(0, 65535)));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule